// File: doc/BRIEF.md
# Dual-Path Watchdog Timer

This block is a watchdog that runs from a slow reference clock, nominally 32.768 kHz. It has two independent paths. The first is a guard counter with a fixed 16-second period. It runs by itself after every reset. If software does not clear its enable bit in time, it pulses the external watchdog pin low for one clock. The second path is a programmable timeout counter. Software arms it once and then services it with a two-word key sequence. If it is not serviced, it pulses the internal reset request. It can also latch the external pin low until the next power-on reset. An interrupt can be raised a programmable number of half-second units before expiry.

Software controls the block through a single-cycle write port with four word addresses. Both reset inputs are asynchronous, active low and released through a two-flop synchronizer. The system reset `rst_n` clears everything except the sticky pin latch. Power-on reset `por_n` clears everything, including that latch.

Top module: `wdog_dual`

## Requirements
- R1: While reset is held, and directly after its release, `wdog_pin_n` and `rst_req_n` are high and `irq` is low.
- R2: With no software action, `wdog_pin_n` goes low exactly once, for one clock, in the `PD_CYCLES + 2`-th cycle after `rst_n` rises (two cycles are the reset synchronizer).
- R3: Writing 0 to bit 0 at address 2 before the guard expires stops the guard and no pulse follows. A later write of 1 does not re-arm it.
- R4: Writing address 0 with bit 2 = 0 drives `wdog_pin_n` low from the next clock. The pin stays low until address 0 is written with bit 2 = 1.
- R5: Writing address 0 with bit 0 = 1 loads the field N in bits [15:8] and starts the counter. `rst_req_n` then pulses low for one clock every (N+1)·`HALF_CYC` clocks, counted from the load edge.
- R6: If bit 1 at address 0 is set when the counter expires, `wdog_pin_n` goes low one clock after the reset request. It stays low through system resets until `por_n` is asserted.
- R7: If bit 1 at address 0 is clear, an expiry leaves `wdog_pin_n` high.
- R8: Writing 16'h5555 and then 16'hAAAA to address 1 reloads the counter at the 16'hAAAA edge. Any other service word clears the pending first key, and an out-of-order sequence does not reload.
- R9: With interval I (1 ≤ I ≤ N) in bits [7:0] at address 3, `irq` rises (N+1−I)·`HALF_CYC` clocks after a load. It stays high until the next reload. I = 0 never raises `irq`.
- R10: Once bit 0 at address 0 has been set, a write that clears it has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, also clears the sticky pin |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Word address: 0 control, 1 service, 2 guard control, 3 interrupt interval |
| wr_data | input | 16 | Write data |
| rst_req_n | output | 1 | Active-low internal reset request pulse on timeout |
| wdog_pin_n | output | 1 | Active-low external watchdog pin |
| irq | output | 1 | Pre-timeout interrupt, active high |

## Verification
The hardest state to reach is the sticky pin surviving a system reset. The stimulus must first let a pin-enabled timeout expire. It then pulses only `rst_n` and checks the pin is still low once the control registers have returned to reset. Only after that does it apply `por_n`. The out-of-order service case is also deliberate: a first key is followed by a wrong word and then a correct second key. The bench shows that the timeout keeps its original deadline. Timeout periods and interrupt intervals are swept over small field values, using a shortened half-second prescale.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL  = 2'd0,
    ADR_SVC   = 2'd1,
    ADR_GUARD = 2'd2,
    ADR_IVL   = 2'd3
  } wdog_addr_e;

  localparam logic [15:0] SVC_KEY_FIRST  = 16'h5555;
  localparam logic [15:0] SVC_KEY_SECOND = 16'hAAAA;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_PIN_BIT  = 1;
  localparam int CTRL_HOLD_BIT = 2;
  localparam int CTRL_TMO_LSB  = 8;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int PD_CYCLES = 524288
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr_req,
  output logic guard_en,
  output logic guard_pulse
);
  localparam int CW = $clog2(PD_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, en_d;
  logic          done_q, done_d;
  logic          pulse_q, pulse_d;
  logic          active;

  assign active = en_q & ~clr_req & ~done_q;

  always_comb begin
    cnt_d   = cnt_q;
    en_d    = en_q & ~clr_req;
    done_d  = done_q;
    pulse_d = 1'b0;
    if (active) begin
      if (cnt_q == CW'(PD_CYCLES - 1)) begin
        pulse_d = 1'b1;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      en_q    <= 1'b1;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      en_q    <= en_d;
      done_q  <= done_d;
      pulse_q <= pulse_d;
    end
  end

  assign guard_en    = en_q;
  assign guard_pulse = pulse_q;
endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout #(
  parameter int HALF_CYC = 16384,
  parameter int TW       = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic          run,
  input  logic [TW-1:0] tmo_val,
  input  logic [TW-1:0] ivl,
  output logic          expire,
  output logic          irq
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          tick;

  assign tick = (pre_q == PW'(HALF_CYC - 1));

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load) begin
      pre_d = '0;
      cnt_d = tmo_val;
    end else if (run) begin
      if (tick) begin
        pre_d = '0;
        if (cnt_q == '0) begin
          exp_d = 1'b1;
          cnt_d = tmo_val;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire = exp_q;
  assign irq    = run & (cnt_q < ivl);
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual #(
  parameter int PD_CYCLES = 524288,
  parameter int HALF_CYC  = 16384,
  parameter int TW        = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        rst_req_n,
  output logic        wdog_pin_n,
  output logic        irq
);
  import wdog_pkg::*;

  logic rst_i_n, por_i_n;

  wdog_rst_sync #(.STAGES(2)) u_sys_sync (
    .clk(clk), .arst_ni(rst_n & por_n), .rst_no(rst_i_n)
  );
  wdog_rst_sync #(.STAGES(2)) u_por_sync (
    .clk(clk), .arst_ni(por_n), .rst_no(por_i_n)
  );

  logic ctrl_wr, svc_wr, guard_wr, ivl_wr;
  assign ctrl_wr  = wr_en & (wr_addr == ADR_CTRL);
  assign svc_wr   = wr_en & (wr_addr == ADR_SVC);
  assign guard_wr = wr_en & (wr_addr == ADR_GUARD);
  assign ivl_wr   = wr_en & (wr_addr == ADR_IVL);

  logic          run_q, run_d;
  logic          pin_on_q, pin_on_d;
  logic          hold_n_q, hold_n_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic [TW-1:0] ivl_q, ivl_d;
  logic          armed_q, armed_d;
  logic          latch_q, latch_d;
  logic          load, svc_done, expire, guard_en, guard_pulse;
  logic          unused_bits;

  assign unused_bits = ^wr_data[7:3];

  assign svc_done = svc_wr & armed_q & (wr_data == SVC_KEY_SECOND) & run_q;
  assign load     = (ctrl_wr & wr_data[CTRL_RUN_BIT] & ~run_q) | svc_done;

  always_comb begin
    run_d    = run_q;
    pin_on_d = pin_on_q;
    hold_n_d = hold_n_q;
    tmo_d    = tmo_q;
    ivl_d    = ivl_q;
    armed_d  = armed_q;
    if (ctrl_wr) begin
      run_d    = run_q | wr_data[CTRL_RUN_BIT];
      pin_on_d = wr_data[CTRL_PIN_BIT];
      hold_n_d = wr_data[CTRL_HOLD_BIT];
      tmo_d    = wr_data[CTRL_TMO_LSB +: TW];
    end
    if (ivl_wr) ivl_d = wr_data[TW-1:0];
    if (svc_wr) armed_d = (wr_data == SVC_KEY_FIRST);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q    <= 1'b0;
      pin_on_q <= 1'b0;
      hold_n_q <= 1'b1;
      tmo_q    <= '0;
      ivl_q    <= '0;
      armed_q  <= 1'b0;
    end else begin
      run_q    <= run_d;
      pin_on_q <= pin_on_d;
      hold_n_q <= hold_n_d;
      tmo_q    <= tmo_d;
      ivl_q    <= ivl_d;
      armed_q  <= armed_d;
    end
  end

  assign latch_d = latch_q | (expire & pin_on_q);

  always_ff @(posedge clk or negedge por_i_n) begin
    if (!por_i_n) latch_q <= 1'b0;
    else          latch_q <= latch_d;
  end

  wdog_guard #(.PD_CYCLES(PD_CYCLES)) u_guard (
    .clk(clk), .rst_ni(rst_i_n),
    .clr_req(guard_wr & ~wr_data[0]),
    .guard_en(guard_en), .guard_pulse(guard_pulse)
  );

  wdog_timeout #(.HALF_CYC(HALF_CYC), .TW(TW)) u_tmo (
    .clk(clk), .rst_ni(rst_i_n), .load(load), .run(run_q),
    .tmo_val(tmo_d), .ivl(ivl_q), .expire(expire), .irq(irq)
  );

  assign rst_req_n  = ~expire;
  assign wdog_pin_n = ~(latch_q | guard_pulse | ~hold_n_q);
endmodule

// File: rtl/wdog_dual_chk.sv
module wdog_dual_chk #(
  parameter int HALF_CYC = 16384
) (
  input logic        clk,
  input logic        rst_ni,
  input logic        por_ni,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        run,
  input logic        guard_en,
  input logic        guard_pulse,
  input logic        latch,
  input logic        rst_req_n,
  input logic        wdog_pin_n,
  input logic        irq
);
  AST_GUARD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    guard_pulse |=> !guard_pulse); // R2
  AST_GUARD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    guard_pulse |-> $past(guard_en)); // R3
  AST_SW_ASSERT_PIN: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == 2'd0 && !wr_data[2]) |=> !wdog_pin_n); // R4
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    ((HALF_CYC > 1) && !rst_req_n) |=> rst_req_n); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!por_ni)
    latch |=> (latch && !wdog_pin_n)); // R6
  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> run); // R9
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    run |=> run); // R10
endmodule

bind wdog_dual wdog_dual_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_ni(rst_i_n), .por_ni(por_i_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run_q), .guard_en(guard_en), .guard_pulse(guard_pulse),
  .latch(latch_q), .rst_req_n(rst_req_n), .wdog_pin_n(wdog_pin_n), .irq(irq)
);

// File: tb/tb_wdog_dual.sv
module tb_wdog_dual;
  localparam int PD  = 40;
  localparam int H   = 4;
  localparam int SYN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        rst_req_n, wdog_pin_n, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int f_req, c_req, f_pin, c_pin, f_irq, c_irq;

  always #2.5 clk = ~clk;

  wdog_dual #(.PD_CYCLES(PD), .HALF_CYC(H), .TW(8)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req_n(rst_req_n),
    .wdog_pin_n(wdog_pin_n), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  task automatic sys_reset(input int settle);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  task automatic observe(input int n);
    f_req = 0; c_req = 0; f_pin = 0; c_pin = 0; f_irq = 0; c_irq = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (!rst_req_n) begin if (f_req == 0) f_req = i; c_req++; end
      if (!wdog_pin_n) begin if (f_pin == 0) f_pin = i; c_pin++; end
      if (irq) begin if (f_irq == 0) f_irq = i; c_irq++; end
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pin in reset", int'(wdog_pin_n), 1);
    chk("R1 req in reset", int'(rst_req_n), 1);
    por_n = 1'b1;
    rst_n = 1'b1;
    // R2 guard fires on its own
    observe(PD + 20);
    chk("R2 guard pulse cycle", f_pin, PD + SYN);
    chk("R2 guard pulse width", c_pin, 1);
    chk("R1 irq idle", c_irq, 0);
    chk("R1 req idle", c_req, 0);

    // R3 guard disabled, no re-arm
    sys_reset(3);
    chk("R1 pin after release", int'(wdog_pin_n), 1);
    wr(2'd2, 16'h0000);
    wr(2'd2, 16'h0001);
    observe(PD + 20);
    chk("R3 no guard pulse", c_pin, 0);

    // R4 software assert
    sys_reset(3);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    chk("R4 pin low after write", int'(wdog_pin_n), 0);
    observe(6);
    chk("R4 pin held low", c_pin, 6);
    wr(2'd0, 16'h0004);
    observe(6);
    chk("R4 pin released", c_pin, 0);

    // R5 / R7 timeout period sweep, pin path off
    for (int n = 0; n < 4; n++) begin
      sys_reset(3);
      wr(2'd2, 16'h0000);
      wr(2'd0, {n[7:0], 8'h05});
      observe(2 * (n + 1) * H);
      chk($sformatf("R5 first expiry N=%0d", n), f_req, (n + 1) * H);
      chk($sformatf("R5 expiry count N=%0d", n), c_req, 2);
      chk($sformatf("R7 pin untouched N=%0d", n), c_pin, 0);
      chk($sformatf("R9 no irq at I=0 N=%0d", n), c_irq, 0);
    end

    // R6 sticky pin through system reset, cleared by por
    sys_reset(3);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0007);
    observe(10);
    chk("R6 req at expiry", f_req, H);
    chk("R6 pin follows", f_pin, H + 1);
    chk("R6 pin stays low", c_pin, 10 - H);
    sys_reset(3);
    wr(2'd2, 16'h0000);
    observe(20);
    chk("R6 pin low through sys reset", c_pin, 20);
    chk("R6 no req after sys reset", c_req, 0);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd2, 16'h0000);
    observe(10);
    chk("R6 pin released by por", c_pin, 0);

    // R8 correct service sequence
    sys_reset(3);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0705);
    repeat (10) @(negedge clk);
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'hAAAA);
    observe(40);
    chk("R8 reload from second key", f_req, 8 * H);

    // R8 broken sequences do not reload
    sys_reset(3);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0705);
    wr(2'd1, 16'hAAAA);
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'h1234);
    wr(2'd1, 16'hAAAA);
    observe(40);
    chk("R8 bad sequence ignored", f_req, 8 * H - 4);

    // R10 enable cannot be cleared
    sys_reset(3);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0105);
    wr(2'd0, 16'h0104);
    observe(20);
    chk("R10 still expires", f_req, 2 * H - 1);
    chk("R10 keeps running", c_req, 2);

    // R9 interrupt interval sweep, N=7
    for (int iv = 1; iv <= 7; iv += 2) begin
      sys_reset(3);
      wr(2'd2, 16'h0000);
      wr(2'd3, 16'(iv));
      wr(2'd0, 16'h0705);
      observe(35);
      chk($sformatf("R9 irq rise I=%0d", iv), f_irq, (8 - iv) * H);
      chk($sformatf("R9 irq width I=%0d", iv), c_irq, iv * H);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule